// File: doc/BRIEF.md
# Synchronized Power-Down Clock Gater

This block parks a group of free-running clocks in the LOW state when an active-low, asynchronous power-down request arrives, and powers the PLL back down and up around them. The request passes through a two-flop synchronizer in the CPU-clock domain. A qualification counter then accepts it only after a run of consecutive LOW samples. Each gated clock has its own enable flop, clocked on the falling edge of that clock's source. A clock can therefore only stop or restart while its source is LOW, so no output ever produces a shortened HIGH phase.

The controller is a five-state machine. `ST_RUN` moves to `ST_QUAL` on the first LOW sample. `ST_QUAL` returns to `ST_RUN` on any HIGH sample, and moves to `ST_STOP` once `QUAL_EDGES` consecutive LOW samples have been seen. In `ST_STOP` every gate is told to stop, and the machine waits `PARK_CYCLES` CPU cycles. It then moves to `ST_OFF`, where the PLL-off output is raised; a HIGH sample in `ST_STOP` goes straight to `ST_SETTLE` instead. `ST_OFF` moves to `ST_SETTLE` on a HIGH sample and drops the PLL-off output. `ST_SETTLE` keeps the gates stopped for `SETTLE_CYCLES` consecutive HIGH samples, restarts that count on any LOW sample, and then returns to `ST_RUN`. The gates restart on their next falling source edge.

The block sits between the clock synthesizer's divider outputs and the output buffers. The same sequence works at any CPU clock rate, because every delay is counted in CPU cycles.

Top module: `pd_clock_gater`

## Requirements
- R1: After reset, `pll_off` is 0 and every `gclk_out[i]` equals `src_clk[i]`.
- R2: A request that is LOW for a single CPU rising edge is ignored: `pll_off` stays 0 and all outputs keep toggling.
- R3: No gated output ever shows a HIGH pulse shorter than half the period of its source, on entry to power-down or on exit from it.
- R4: While `pll_off` is 1, every `gclk_out` bit is LOW.
- R5: With the request held LOW from before CPU rising edge 1, `pll_off` is 0 after edge 19 and 1 after edge 20 (2 sync stages + `QUAL_EDGES`=2 + `PARK_CYCLES`=16). All outputs are already parked at that point.
- R6: When the request returns HIGH from the parked state before edge 1, `pll_off` is still 1 after edge 2 and 0 after edge 3. The outputs stay LOW through edge 10 (`SETTLE_CYCLES`=8) and toggle again afterwards.
- R7: A LOW request spanning L CPU rising edges raises `pll_off` exactly when L >= 18 (`QUAL_EDGES` + `PARK_CYCLES`). Shorter qualified requests stop and restart the outputs without powering the PLL down.
- R8: A LOW sample during settling restarts the settle count. A one-edge LOW at edge 6 of a release keeps the outputs LOW, with `pll_off` 0, through edge 14.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cpu_clk | input | 1 | CPU clock; controller and synchronizer domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_req_n | input | 1 | Asynchronous power-down request, active LOW |
| src_clk | input | N_CLK | Free-running source clocks, one per output |
| gclk_out | output | N_CLK | Gated clocks, parked LOW during power-down |
| pll_off | output | 1 | PLL disable, HIGH while powered down |

## Verification
The request is driven with a single-edge LOW glitch, which shows whether the qualification counter really requires consecutive samples. Lengths of 17 and 18 edges bracket the point where the PLL is turned off. Short qualified pulses stop and restart the outputs while the PLL stays on, and long pulses reach full power-down. A LOW glitch in the middle of settling shows whether the settle count restarts. Seeded random request lengths drawn from all three classes are mixed in. Four source clocks with unrelated half-periods run throughout, and every HIGH pulse is measured against its source half-period, so that any runt on entry or exit is caught.

// File: rtl/pdg_pkg.sv
package pdg_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_QUAL,
        ST_STOP,
        ST_OFF,
        ST_SETTLE
    } pdg_state_e;

endpackage

// File: rtl/pdg_sync.sv
module pdg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= 1'b1;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/pdg_ctrl.sv
module pdg_ctrl
    import pdg_pkg::*;
#(
    parameter int QUAL_EDGES    = 2,
    parameter int PARK_CYCLES   = 16,
    parameter int SETTLE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_s_n,
    output logic stop_req,
    output logic pll_off
);

    localparam int QW   = $clog2(QUAL_EDGES + 1);
    localparam int CMAX = (PARK_CYCLES > SETTLE_CYCLES) ? PARK_CYCLES : SETTLE_CYCLES;
    localparam int CW   = $clog2(CMAX + 1);

    localparam logic [QW-1:0] QUAL_LAST   = QW'(QUAL_EDGES - 1);
    localparam logic [CW-1:0] PARK_LAST   = CW'(PARK_CYCLES - 1);
    localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYCLES - 1);

    pdg_state_e    st_q, st_nxt;
    logic [QW-1:0] qcnt_q, qcnt_nxt;
    logic [CW-1:0] cnt_q, cnt_nxt;

    // next-state decode
    always_comb begin
        st_nxt   = st_q;
        qcnt_nxt = qcnt_q;
        cnt_nxt  = cnt_q;
        unique case (st_q)
            ST_RUN: begin
                if (!req_s_n) begin
                    if (QUAL_EDGES <= 1) begin
                        st_nxt  = ST_STOP;
                        cnt_nxt = '0;
                    end else begin
                        st_nxt   = ST_QUAL;
                        qcnt_nxt = QW'(1);
                    end
                end
            end
            ST_QUAL: begin
                if (req_s_n) begin
                    st_nxt = ST_RUN;
                end else if (qcnt_q == QUAL_LAST) begin
                    st_nxt  = ST_STOP;
                    cnt_nxt = '0;
                end else begin
                    qcnt_nxt = qcnt_q + QW'(1);
                end
            end
            ST_STOP: begin
                if (req_s_n) begin
                    st_nxt  = ST_SETTLE;
                    cnt_nxt = '0;
                end else if (cnt_q == PARK_LAST) begin
                    st_nxt = ST_OFF;
                end else begin
                    cnt_nxt = cnt_q + CW'(1);
                end
            end
            ST_OFF: begin
                if (req_s_n) begin
                    st_nxt  = ST_SETTLE;
                    cnt_nxt = '0;
                end
            end
            ST_SETTLE: begin
                if (!req_s_n) begin
                    cnt_nxt = '0;
                end else if (cnt_q == SETTLE_LAST) begin
                    st_nxt = ST_RUN;
                end else begin
                    cnt_nxt = cnt_q + CW'(1);
                end
            end
            default: st_nxt = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_RUN;
            qcnt_q <= '0;
            cnt_q  <= '0;
        end else begin
            st_q   <= st_nxt;
            qcnt_q <= qcnt_nxt;
            cnt_q  <= cnt_nxt;
        end
    end

    // registered outputs, aligned with the state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stop_req <= 1'b0;
            pll_off  <= 1'b0;
        end else begin
            stop_req <= (st_nxt == ST_STOP) || (st_nxt == ST_OFF) || (st_nxt == ST_SETTLE);
            pll_off  <= (st_nxt == ST_OFF);
        end
    end

endmodule

// File: rtl/pdg_gate.sv
module pdg_gate (
    input  logic src_clk,
    input  logic rst_n,
    input  logic stop_req,
    output logic en,
    output logic gclk
);

    // enable only moves while the source is LOW
    always_ff @(negedge src_clk or negedge rst_n) begin
        if (!rst_n) en <= 1'b1;
        else        en <= !stop_req;
    end

    assign gclk = src_clk & en;

endmodule

// File: rtl/pd_clock_gater.sv
module pd_clock_gater #(
    parameter int N_CLK         = 4,
    parameter int SYNC_STAGES   = 2,
    parameter int QUAL_EDGES    = 2,
    parameter int PARK_CYCLES   = 16,
    parameter int SETTLE_CYCLES = 8
) (
    input  logic             cpu_clk,
    input  logic             rst_n,
    input  logic             pd_req_n,
    input  logic [N_CLK-1:0] src_clk,
    output logic [N_CLK-1:0] gclk_out,
    output logic             pll_off
);

    logic             req_s_n;
    logic             stop_req;
    logic [N_CLK-1:0] gate_en;

    pdg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (cpu_clk),
        .rst_n (rst_n),
        .d     (pd_req_n),
        .q     (req_s_n)
    );

    pdg_ctrl #(
        .QUAL_EDGES    (QUAL_EDGES),
        .PARK_CYCLES   (PARK_CYCLES),
        .SETTLE_CYCLES (SETTLE_CYCLES)
    ) u_ctrl (
        .clk      (cpu_clk),
        .rst_n    (rst_n),
        .req_s_n  (req_s_n),
        .stop_req (stop_req),
        .pll_off  (pll_off)
    );

    generate
        for (genvar i = 0; i < N_CLK; i++) begin : g_gate
            pdg_gate u_gate (
                .src_clk  (src_clk[i]),
                .rst_n    (rst_n),
                .stop_req (stop_req),
                .en       (gate_en[i]),
                .gclk     (gclk_out[i])
            );
        end
    endgenerate

endmodule

// File: rtl/pdg_chk.sv
module pdg_chk #(
    parameter int N_CLK = 4
) (
    input logic             cpu_clk,
    input logic             rst_n,
    input logic             req_s_n,
    input logic             stop_req,
    input logic             pll_off,
    input logic [N_CLK-1:0] gate_en,
    input logic [N_CLK-1:0] gclk_out,
    input logic [N_CLK-1:0] src_clk
);

    // stop only after two consecutive synchronized LOW samples
    p_qual_two_r2: assert property (@(posedge cpu_clk) disable iff (!rst_n)
        $rose(stop_req) |-> (!req_s_n && $past(!req_s_n)));

    // parked outputs while the PLL is off
    p_parked_low_r4: assert property (@(posedge cpu_clk) disable iff (!rst_n)
        pll_off |-> (gclk_out == '0));

    // PLL goes off only after every gate has closed
    p_pll_after_park_r5: assert property (@(posedge cpu_clk) disable iff (!rst_n)
        $rose(pll_off) |-> (gate_en == '0));

    // PLL comes back first, outputs still held
    p_pll_clear_first_r6: assert property (@(posedge cpu_clk) disable iff (!rst_n)
        $fell(pll_off) |-> (req_s_n && stop_req));

    generate
        for (genvar i = 0; i < N_CLK; i++) begin : g_chk
            // a gate reopens only with the PLL running
            p_reopen_pll_on_r6: assert property (@(posedge src_clk[i]) disable iff (!rst_n)
                $rose(gate_en[i]) |-> !pll_off);
        end
    endgenerate

endmodule

bind pd_clock_gater pdg_chk #(.N_CLK(N_CLK)) u_pdg_chk (
    .cpu_clk  (cpu_clk),
    .rst_n    (rst_n),
    .req_s_n  (req_s_n),
    .stop_req (stop_req),
    .pll_off  (pll_off),
    .gate_en  (gate_en),
    .gclk_out (gclk_out),
    .src_clk  (src_clk)
);

// File: tb/tb_pd_clock_gater.sv
`timescale 1ns/100ps
module tb_pd_clock_gater;

    localparam int N      = 4;
    localparam int QUAL   = 2;
    localparam int PARK   = 16;
    localparam int SETTLE = 8;
    localparam int HALF [N] = '{5, 8, 15, 4};

    logic         cpu_clk = 1'b0;
    logic         rst_n;
    logic         pd_req_n;
    logic [N-1:0] src;
    logic         src_b [N];
    logic [N-1:0] gclk;
    logic         pll_off;

    int checks = 0;
    int errors = 0;

    bit           pll_seen;
    logic [N-1:0] seen_hi;

    real t_rise [N];
    int  runt   [N];
    int  pulses [N];

    always #2.5 cpu_clk = ~cpu_clk;

    pd_clock_gater #(
        .N_CLK         (N),
        .SYNC_STAGES   (2),
        .QUAL_EDGES    (QUAL),
        .PARK_CYCLES   (PARK),
        .SETTLE_CYCLES (SETTLE)
    ) dut (
        .cpu_clk  (cpu_clk),
        .rst_n    (rst_n),
        .pd_req_n (pd_req_n),
        .src_clk  (src),
        .gclk_out (gclk),
        .pll_off  (pll_off)
    );

    // sources and HIGH-pulse width monitors (R3)
    for (genvar g = 0; g < N; g++) begin : g_src
        initial begin
            src_b[g] = 1'b0;
            runt[g] = 0;
            pulses[g] = 0;
            t_rise[g] = 0.0;
            forever #(HALF[g]) src_b[g] = ~src_b[g];
        end
        assign src[g] = src_b[g];
        always @(posedge gclk[g]) t_rise[g] = $realtime;
        always @(negedge gclk[g]) begin
            if (rst_n === 1'b1) begin
                pulses[g]++;
                if (($realtime - t_rise[g]) < (HALF[g] - 0.01)) runt[g]++;
            end
        end
    end

    function automatic bit exp_off(int len);
        return len >= (QUAL + PARK);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_seen();
        pll_seen = 1'b0;
        seen_hi  = '0;
    endtask

    task automatic cycles(int n);
        repeat (n) begin
            @(posedge cpu_clk);
            #1;
            if (pll_off) pll_seen = 1'b1;
            seen_hi |= gclk;
        end
    endtask

    // request LOW for exactly len CPU rising edges
    task automatic pulse_req(int len);
        clear_seen();
        @(negedge cpu_clk);
        pd_req_n = 1'b0;
        cycles(len);
        @(negedge cpu_clk);
        pd_req_n = 1'b1;
    endtask

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4711);
        rst_n    = 1'b0;
        pd_req_n = 1'b1;
        clear_seen();
        repeat (4) @(posedge cpu_clk);
        @(negedge cpu_clk);
        rst_n = 1'b1;

        // R1 reset state
        cycles(20);
        chk(pll_off == 1'b0, "R1", "pll_off after reset", int'(pll_off), 0);
        chk(gclk == src, "R1", "outputs follow sources", int'(gclk), int'(src));
        chk(seen_hi == '1, "R1", "outputs toggle", int'(seen_hi), (1 << N) - 1);

        // R2 single-edge glitch ignored
        clear_seen();
        @(negedge cpu_clk);
        pd_req_n = 1'b0;
        @(negedge cpu_clk);
        pd_req_n = 1'b1;
        cycles(40);
        chk(!pll_seen, "R2", "glitch pll_off", int'(pll_seen), 0);
        chk(seen_hi == '1, "R2", "glitch outputs running", int'(seen_hi), (1 << N) - 1);

        // R5 exact entry latency, R4 parked
        @(negedge cpu_clk);
        pd_req_n = 1'b0;
        cycles(19);
        chk(pll_off == 1'b0, "R5", "pll_off at edge 19", int'(pll_off), 0);
        cycles(1);
        chk(pll_off == 1'b1, "R5", "pll_off at edge 20", int'(pll_off), 1);
        chk(gclk == '0, "R5", "outputs parked at pll off", int'(gclk), 0);
        clear_seen();
        cycles(20);
        chk(seen_hi == '0, "R4", "outputs LOW while parked", int'(seen_hi), 0);

        // R6 release order
        @(negedge cpu_clk);
        pd_req_n = 1'b1;
        cycles(2);
        chk(pll_off == 1'b1, "R6", "pll_off at release edge 2", int'(pll_off), 1);
        cycles(1);
        chk(pll_off == 1'b0, "R6", "pll_off at release edge 3", int'(pll_off), 0);
        clear_seen();
        cycles(7);
        chk(seen_hi == '0, "R6", "outputs held during settle", int'(seen_hi), 0);
        clear_seen();
        cycles(30);
        chk(seen_hi == '1, "R6", "outputs restart", int'(seen_hi), (1 << N) - 1);

        // R8 LOW sample during settle restarts the count
        @(negedge cpu_clk);
        pd_req_n = 1'b0;
        cycles(30);
        @(negedge cpu_clk);
        pd_req_n = 1'b1;
        cycles(5);
        @(negedge cpu_clk);
        pd_req_n = 1'b0;
        @(negedge cpu_clk);
        pd_req_n = 1'b1;
        clear_seen();
        cycles(8);
        chk(pll_off == 1'b0, "R8", "pll stays on after settle glitch", int'(pll_off), 0);
        chk(seen_hi == '0, "R8", "outputs held to edge 14", int'(seen_hi), 0);
        clear_seen();
        cycles(30);
        chk(seen_hi == '1, "R8", "outputs restart after settle", int'(seen_hi), (1 << N) - 1);

        // R7 boundary lengths
        pulse_req(17);
        cycles(40);
        chk(pll_seen == exp_off(17), "R7", "len 17 pll_off", int'(pll_seen), int'(exp_off(17)));
        pulse_req(18);
        cycles(40);
        chk(pll_seen == exp_off(18), "R7", "len 18 pll_off", int'(pll_seen), int'(exp_off(18)));

        // R7 random lengths across the three classes
        for (int it = 0; it < 12; it++) begin
            int kind;
            int len;
            kind = int'($urandom % 3);
            if (kind == 0)      len = 1;
            else if (kind == 1) len = 3 + int'($urandom % 10);
            else                len = 25 + int'($urandom % 20);
            pulse_req(len);
            cycles(40);
            chk(pll_seen == exp_off(len), "R7", $sformatf("len %0d pll_off", len),
                int'(pll_seen), int'(exp_off(len)));
            clear_seen();
            cycles(20);
            chk(seen_hi == '1, "R6", "outputs running after random request",
                int'(seen_hi), (1 << N) - 1);
        end

        // R3 no runt HIGH pulses on any output
        for (int i = 0; i < N; i++) begin
            chk(runt[i] == 0, "R3", $sformatf("runt pulses on output %0d", i), runt[i], 0);
            chk(pulses[i] > 0, "R3", $sformatf("pulses seen on output %0d", i), pulses[i], 1);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule